// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Unit

This block watches 32 already-synchronized GPIO input levels and turns selected transitions or levels into per-pin pending flags. Each pin has a 4-bit sense field that picks its trigger condition. Each pin's flag is gated by an accept bit, held until software clears it by writing a one, and forwarded to one of two interrupt request lines through a per-pin enable mask.

All control and status sits on a simple single-cycle register bus. A write is a one-cycle `reg_we` strobe with address and data. A read is combinational: `reg_rdata` follows `reg_addr`. The input synchronizers belong to the GPIO port and sit outside this block.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, all pending flags, enable bits, accept bits, sense fields and the previous-sample register are zero. Every readable offset returns 0 and both request lines are low.
- R2: Sense code bits [2:0] select the trigger. 0 fires on a rising edge, 1 on a falling edge and 4 on either edge. Pin n's field is at offset 0x40+4*(n/8), bits [4*(n%8)+3 : 4*(n%8)], and reads back unchanged.
- R3: Code 2 (high level) raises the pending flag in every cycle the input is 1. Code 3 (low level) raises it in every cycle the input is 0.
- R4: Codes 5, 6 and 7 never raise a pending flag. Field bit 3 (asynchronous select) is stored and read back but does not change detection.
- R5: The accept register at offset 0x14 is read/write. A pin whose accept bit is 0 never gets its pending flag set, whatever its input does.
- R6: Writing ones to offset 0x18 sets those enable bits, and writing ones to offset 0x1C clears them. A read of 0x1C returns the enable mask, and a read of 0x18 returns 0.
- R7: Offset 0x20 reads the raw pending flags. Offset 0x24 reads pending AND enable.
- R8: Writing ones to offset 0x28 clears those pending flags on the next edge. A detection on that pin in the same cycle wins, and the flag stays set. A still-active level therefore keeps its flag set.
- R9: `irq_lo` is high whenever any masked bit of pins 0–15 is set, and `irq_hi` likewise for pins 16–31. Both are level outputs.
- R10: Edges are found by comparing each input with its value from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pin_sync | input | 32 | Synchronized GPIO input levels |
| irq_lo | output | 1 | Request for pins 0–15 |
| irq_hi | output | 1 | Request for pins 16–31 |

## Verification
Two events can meet on one pin in the same cycle: a write-one-to-clear and a fresh detection. The bench provokes this by raising a rising-edge pin in the very cycle that its clear is written. It also holds a level-sensed pin active while clearing it. A set-wins reference model expects the flag still set in both cases, and this is judged through the raw and masked status reads and the request lines. An enable-clear landing on an already pending pin is also covered: the request must drop while the raw flag stays.

// File: rtl/gis_pkg.sv
package gis_pkg;
  typedef enum logic [2:0] {
    SNS_RISE = 3'd0,
    SNS_FALL = 3'd1,
    SNS_HIGH = 3'd2,
    SNS_LOW  = 3'd3,
    SNS_BOTH = 3'd4
  } sense_e;

  localparam logic [7:0] OFF_ACCEPT = 8'h14;
  localparam logic [7:0] OFF_EN_SET = 8'h18;
  localparam logic [7:0] OFF_EN_CLR = 8'h1C;
  localparam logic [7:0] OFF_RAW    = 8'h20;
  localparam logic [7:0] OFF_MASKED = 8'h24;
  localparam logic [7:0] OFF_CLEAR  = 8'h28;
  localparam logic [7:0] OFF_SENSE0 = 8'h40;

  // trigger decision for one pin from its code, current and previous level
  function automatic logic sense_hit(logic [2:0] code, logic cur, logic prev);
    case (code)
      SNS_RISE: return cur & ~prev;
      SNS_FALL: return ~cur & prev;
      SNS_HIGH: return cur;
      SNS_LOW:  return ~cur;
      SNS_BOTH: return cur ^ prev;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gis_pin_detect.sv
module gis_pin_detect
  import gis_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [2:0] code,
  output logic       evt
);
  logic prev_q;

  // R10: previous-cycle sample for edge comparison
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin;
  end

  assign evt = sense_hit(code, pin, prev_q);
endmodule

// File: rtl/gis_status.sv
module gis_status #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_we,
  input  logic [NUM_PINS-1:0] acc_wdata,
  input  logic [NUM_PINS-1:0] en_set,
  input  logic [NUM_PINS-1:0] en_clr,
  input  logic [NUM_PINS-1:0] clr,
  input  logic [NUM_PINS-1:0] evt,
  output logic [NUM_PINS-1:0] pend,
  output logic [NUM_PINS-1:0] en,
  output logic [NUM_PINS-1:0] acc
);
  logic [NUM_PINS-1:0] pend_q, en_q, acc_q;
  logic [NUM_PINS-1:0] set_gated;

  assign set_gated = evt & acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      acc_q  <= '0;
    end else begin
      if (acc_we) acc_q <= acc_wdata;
      en_q   <= (en_q | en_set) & ~en_clr;
      pend_q <= (pend_q & ~clr) | set_gated;
    end
  end

  assign pend = pend_q;
  assign en   = en_q;
  assign acc  = acc_q;

  // R5
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(acc_q)) == '0));
  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & $past(clr & ~evt)) == '0));
  // R6
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set != '0) |=> ((en_q & $past(en_set)) == $past(en_set)));
  // R6
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr != '0) |=> ((en_q & $past(en_clr)) == '0));
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gis_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [7:0]          reg_addr,
  input  logic [NUM_PINS-1:0] reg_wdata,
  output logic [NUM_PINS-1:0] reg_rdata,
  input  logic [NUM_PINS-1:0] pin_sync,
  output logic                irq_lo,
  output logic                irq_hi
);
  localparam int FIELD_W   = 4;
  localparam int PER_REG   = NUM_PINS / FIELD_W;
  localparam int SENSE_REGS = NUM_PINS / PER_REG;
  localparam int HALF      = NUM_PINS / 2;

  logic [FIELD_W*NUM_PINS-1:0] sense_q;
  logic [NUM_PINS-1:0] evt, pend, en, acc, masked;
  logic wr_acc, wr_en_set, wr_en_clr, wr_clr;

  assign wr_acc    = reg_we && (reg_addr == OFF_ACCEPT);
  assign wr_en_set = reg_we && (reg_addr == OFF_EN_SET);
  assign wr_en_clr = reg_we && (reg_addr == OFF_EN_CLR);
  assign wr_clr    = reg_we && (reg_addr == OFF_CLEAR);

  // R2 / R4: sense field registers, eight fields per word
  for (genvar k = 0; k < SENSE_REGS; k++) begin : g_sense
    localparam logic [7:0] MY_OFF = OFF_SENSE0 + 8'(4 * k);
    always_ff @(posedge clk) begin
      if (!rst_n) sense_q[NUM_PINS*k +: NUM_PINS] <= '0;
      else if (reg_we && reg_addr == MY_OFF)
        sense_q[NUM_PINS*k +: NUM_PINS] <= reg_wdata;
    end
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    gis_pin_detect u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_sync[n]),
      .code (sense_q[FIELD_W*n +: 3]),
      .evt  (evt[n])
    );
  end

  gis_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_we   (wr_acc),
    .acc_wdata(reg_wdata),
    .en_set   (wr_en_set ? reg_wdata : '0),
    .en_clr   (wr_en_clr ? reg_wdata : '0),
    .clr      (wr_clr ? reg_wdata : '0),
    .evt      (evt),
    .pend     (pend),
    .en       (en),
    .acc      (acc)
  );

  assign masked = pend & en;
  assign irq_lo = |masked[HALF-1:0];
  assign irq_hi = |masked[NUM_PINS-1:HALF];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_ACCEPT: reg_rdata = acc;
      OFF_EN_CLR: reg_rdata = en;
      OFF_RAW:    reg_rdata = pend;
      OFF_MASKED: reg_rdata = masked;
      default: begin
        for (int k = 0; k < SENSE_REGS; k++)
          if (reg_addr == OFF_SENSE0 + 8'(4 * k))
            reg_rdata = sense_q[NUM_PINS*k +: NUM_PINS];
      end
    endcase
  end

  // R9: a raised request holds until a clear or an enable-clear is written
  irq_lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo && !wr_clr && !wr_en_clr) |=> irq_lo);
  // R9
  irq_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi && !wr_clr && !wr_en_clr) |=> irq_hi);
endmodule

// File: tb/gpio_irq_sense_bench.sv
module gpio_irq_sense_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins = '0;
  logic        irq_lo, irq_hi;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_sense u_gpio_irq_sense (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .pin_sync(pins),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // behavioural reference model
  logic [31:0] m_pend, m_en, m_acc, m_prev;
  logic [3:0]  m_sense [32];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend <= '0; m_en <= '0; m_acc <= '0; m_prev <= '0;
      for (int i = 0; i < 32; i++) m_sense[i] <= 4'h0;
    end else begin
      for (int i = 0; i < 32; i++) begin
        bit hit, cl;
        case (m_sense[i][2:0])
          3'd0: hit = pins[i] && !m_prev[i];   // R2 rising
          3'd1: hit = !pins[i] && m_prev[i];   // R2 falling
          3'd2: hit = pins[i];                 // R3 high
          3'd3: hit = !pins[i];                // R3 low
          3'd4: hit = pins[i] != m_prev[i];    // R2 both
          default: hit = 0;                    // R4
        endcase
        cl = we && addr == 8'h28 && wdata[i];
        m_pend[i] <= (m_pend[i] && !cl) || (hit && m_acc[i]);
        if (we && addr == 8'h40 + 8'(4 * (i / 8)))
          m_sense[i] <= wdata[4*(i%8) +: 4];
      end
      m_prev <= pins;
      if (we && addr == 8'h14) m_acc <= wdata;
      if (we && addr == 8'h18) m_en <= m_en | wdata;
      if (we && addr == 8'h1C) m_en <= m_en & ~wdata;
    end
  end

  function automatic logic [31:0] model_read(logic [7:0] a);
    logic [31:0] v = '0;
    case (a)
      8'h14: v = m_acc;
      8'h1C: v = m_en;
      8'h20: v = m_pend;
      8'h24: v = m_pend & m_en;
      8'h40, 8'h44, 8'h48, 8'h4C:
        for (int j = 0; j < 8; j++) v[4*j +: 4] = m_sense[(a - 8'h40) * 2 + j];
      default: v = '0;
    endcase
    return v;
  endfunction

  // R9: request lines compared every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic el, eh;
      el = |(m_pend[15:0] & m_en[15:0]);
      eh = |(m_pend[31:16] & m_en[31:16]);
      checks++;
      if (irq_lo !== el) begin
        fails++; $display("FAIL R9 irq_lo actual %b expected %b", irq_lo, el);
      end
      checks++;
      if (irq_hi !== eh) begin
        fails++; $display("FAIL R9 irq_hi actual %b expected %b", irq_hi, eh);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk); pins = v;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk); addr = a; #1;
    e = model_read(a);
    checks++;
    if (rdata !== e) begin
      fails++;
      $display("FAIL %s addr %h actual %h expected %h", tag, a, rdata, e);
    end
  endtask

  task automatic rd_all(input string tag);
    rd_chk(8'h20, tag); rd_chk(8'h24, tag); rd_chk(8'h1C, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    rd_chk(8'h14, "R1"); rd_chk(8'h18, "R1"); rd_chk(8'h1C, "R1");
    rd_chk(8'h20, "R1"); rd_chk(8'h24, "R1"); rd_chk(8'h40, "R1");
    rd_chk(8'h4C, "R1");

    // R2 R4: sense fields, pin5 carries async bit, pin9 code 5
    wr(8'h40, 32'h1483_4321);   // p0=1? see fields below
    wr(8'h40, 32'h1484_3210);   // p0 rise,p1 fall,p2 high,p3 low,p4 both,p5 async-rise,p6 both,p7 fall
    wr(8'h44, 32'h0000_0050);   // p9 code 5 (R4)
    wr(8'h48, 32'h0000_0000);   // p16 rising
    wr(8'h4C, 32'h7000_0002);   // p24 high level, p31 code 7
    rd_chk(8'h40, "R2"); rd_chk(8'h44, "R4"); rd_chk(8'h4C, "R4");

    // R5: toggles with accept low leave pending clear
    set_pins(32'hFFFF_FFFF); set_pins(32'h0); set_pins(32'h0300_0223);
    rd_chk(8'h20, "R5");

    // R6: enable set/clear and readback
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h0000_0004);
    rd_chk(8'h1C, "R6"); rd_chk(8'h18, "R6");

    set_pins(32'h0);
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk(8'h14, "R5");
    // R3: p3 low-level pending; p2 masked; R7 raw vs masked
    rd_all("R3");
    // R10 R2: edge patterns
    set_pins(32'h0001_0231); rd_all("R10");
    set_pins(32'h0100_0090); rd_all("R2");
    set_pins(32'h8000_0000); rd_all("R4");
    rd_chk(8'h24, "R7");

    // R8: plain clear, then collision of clear with a new rising edge on p0
    wr(8'h28, 32'hFFFF_FFFF); rd_all("R8");
    set_pins(32'h0000_0000);
    @(negedge clk); pins = 32'h0000_0001; we = 1'b1; addr = 8'h28; wdata = 32'h0000_0001;
    @(negedge clk); we = 1'b0;
    rd_all("R8");
    // R8: level pin p24 held high stays pending through clear
    set_pins(32'h0100_0000);
    wr(8'h28, 32'h0100_0000); rd_all("R8");
    // R9: enable-clear on a pending pin drops request, raw stays
    wr(8'h1C, 32'hFFFF_FFFF); rd_all("R9");
    wr(8'h18, 32'h0100_0001); rd_all("R9");
    repeat (5) set_pins(32'h0000_0010);
    set_pins(32'h0000_0000); rd_all("R2");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule